// File: doc/BRIEF.md
# Edge-Capturing Interrupt Aggregator with Slot Remapping

This block collects 64 interrupt request lines into two 32-bit banks and raises one interrupt line towards the processor. Each request line is synchronised and watched for rising edges. An edge sets a sticky flag that stays set until software clears it. A byte-wide slot table decides which source feeds each pending position. A pending position is reported only while its per-slot enable bit is set. A global enable bit in the control word gates the output.

Software reaches every register through a zero-wait-state APB slave port. After reset the enables are all zero. The slot table starts in a fixed pattern, so firmware can either keep that pattern or rewrite any slot to route a different source into a pending position.

Top module: `irq_hub`

## Requirements
- R1: After reset, irq_o is 0, and the control word, both enable words and both flag words read 0. Each slot-table word at byte offset 0x40+4w (w = 0..15) reads {4w, 4w+1, 4w+2, 4w+3} from byte 3 down to byte 0, so slot n (byte n%4 of word n/4) holds 4*(n/4) + 3 - n%4.
- R2: Word offsets are: control 0x00, low flag 0x08, low enable 0x10, low pending 0x14, high flag 0x20, high enable 0x28, high pending 0x2C, slot table 0x40-0x7C. The low bank holds bits 0-31 and the high bank holds bits 32-63 of each 64-bit quantity. Each flag word sits 8 bytes below the enable word of its bank.
- R3: pready_o is always 1. A read of an unmapped or non-word-aligned offset returns 0, and a write to such an offset changes no register.
- R4: A 0-to-1 transition on src_i[s] sets flag bit s. The bit is visible 3 rising edges after the input changes. A level that stays high does not set the flag again once it has been cleared.
- R5: Writing a flag word clears every bit written as 0 and leaves every bit written as 1 unchanged. If a source edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: Pending bit n equals flag[slot n bits 5:0] AND enable bit n. The pending words are read-only, so writes to them are ignored.
- R7: The slot table can be read and written as whole words. All 8 bits of each slot are stored, and only bits 5:0 select the source.
- R8: Only control bit 31 (the global enable) is stored. The other control bits read 0.
- R9: irq_o is registered. It equals control bit 31 AND the OR of all 64 pending bits, as they stood before the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| src_i | input | 64 | Interrupt request lines |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
A source edge driven between clock edges reaches the flag 3 rising edges later, and reaches irq_o 4 rising edges later. The bench samples irq_o on the falling edge after the third and after the fourth rising edge to pin both stages. A flag or enable write takes effect at the rising edge of its access phase, so irq_o still shows the old value at the following falling edge and the new value one cycle after that. The bench checks both points. Read data is combinational in the access phase and is sampled there. Random pulse sets are held for three cycles and then released for four, so every flag has settled before the readback.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_BANK = 2;
  localparam int unsigned FLAG_GAP = 8;

  localparam logic [6:0] OFS_CTRL    = 7'h00;
  localparam logic [6:0] OFS_EN_LO   = 7'h10;
  localparam logic [6:0] OFS_PEND_LO = 7'h14;
  localparam logic [6:0] OFS_EN_HI   = 7'h28;
  localparam logic [6:0] OFS_PEND_HI = 7'h2C;
  localparam logic [6:0] OFS_FLAG_LO = OFS_EN_LO - 7'(FLAG_GAP);
  localparam logic [6:0] OFS_FLAG_HI = OFS_EN_HI - 7'(FLAG_GAP);

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_FLAG, SEL_EN, SEL_PEND, SEL_SLOT
  } reg_sel_e;

  // reset pattern: same base per word, offsets 3..0 from byte 0 upward
  function automatic logic [7:0] slot_init(int unsigned n);
    return 8'((n & ~32'd3) + 32'd3 - (n % 4));
  endfunction
endpackage

// File: rtl/irq_hub_capture.sv
`timescale 1ns/1ps
module irq_hub_capture #(
  parameter int unsigned NUM_BANK    = 2,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_SRC    = NUM_BANK * DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic [NUM_BANK-1:0] clr_we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_SRC-1:0]  flag_o
);
  logic [NUM_SRC-1:0] sync_q [SYNC_STAGES];
  logic [NUM_SRC-1:0] prev_q, rise, flag_q, flag_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= src_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    // hardware set is ORed last so it wins over a clear
    assign flag_d[b*DATA_W +: DATA_W] =
      (clr_we_i[b] ? (flag_q[b*DATA_W +: DATA_W] & wdata_i)
                   : flag_q[b*DATA_W +: DATA_W]) | rise[b*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  p_rise_sets_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((flag_q & $past(rise)) == $past(rise)));

  p_flag_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i == '0) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/irq_hub_map.sv
`timescale 1ns/1ps
module irq_hub_map
  import irq_hub_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 64,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SLOT_W   = 8,
  localparam int unsigned PER_WORD = DATA_W / SLOT_W,
  localparam int unsigned NUM_WORD = NUM_SRC / PER_WORD,
  localparam int unsigned IDX_W    = $clog2(NUM_SRC),
  localparam int unsigned WIDX_W   = $clog2(NUM_WORD)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [WIDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [WIDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [SLOT_W-1:0] slot_q [NUM_SRC];

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_slot
    localparam int unsigned W = n / PER_WORD;
    localparam int unsigned B = n % PER_WORD;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[n] <= SLOT_W'(slot_init(n));
      else if (we_i && widx_i == WIDX_W'(W))
        slot_q[n] <= wdata_i[B*SLOT_W +: SLOT_W];
    end
    assign pend_o[n] = flag_i[slot_q[n][IDX_W-1:0]] & en_i[n];
  end

  always_comb begin
    for (int b = 0; b < PER_WORD; b++)
      rdata_o[b*SLOT_W +: SLOT_W] = slot_q[IDX_W'(int'(ridx_i) * PER_WORD + b)];
  end

  p_pend_needs_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o != '0) |-> (flag_i != '0));

  p_pend_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (pend_o == '0));
endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SLOT_W      = 8,
  localparam int unsigned NUM_SRC    = NUM_BANK * DATA_W,
  localparam int unsigned BANK_W     = $clog2(NUM_BANK),
  localparam int unsigned WIDX_W     = $clog2(NUM_SRC * SLOT_W / DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  input  logic [63:0]       src_i,
  output logic              irq_o
);
  reg_sel_e                 sel;
  logic [BANK_W-1:0]        bank;
  logic                     wr;
  logic                     ctrl_en_q;
  logic [NUM_BANK-1:0][DATA_W-1:0] en_q;
  logic [NUM_BANK-1:0]      flag_we;
  logic [NUM_SRC-1:0]       flag, pend, en_flat;
  logic [DATA_W-1:0]        slot_rdata;
  logic                     irq_q;
  logic [6:0]               ofs;

  assign pready_o = 1'b1;
  assign wr       = psel_i & penable_i & pwrite_i;
  assign ofs      = paddr_i[6:0];

  always_comb begin
    sel  = SEL_NONE;
    bank = '0;
    if (paddr_i[ADDR_W-1:7] == '0 && paddr_i[1:0] == 2'b00) begin
      if (ofs[6]) sel = SEL_SLOT;
      else begin
        case (ofs)
          OFS_CTRL:    sel = SEL_CTRL;
          OFS_FLAG_LO: sel = SEL_FLAG;
          OFS_EN_LO:   sel = SEL_EN;
          OFS_PEND_LO: sel = SEL_PEND;
          OFS_FLAG_HI: begin sel = SEL_FLAG; bank = BANK_W'(1); end
          OFS_EN_HI:   begin sel = SEL_EN;   bank = BANK_W'(1); end
          OFS_PEND_HI: begin sel = SEL_PEND; bank = BANK_W'(1); end
          default:     sel = SEL_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_en_q <= 1'b0;
    else if (wr && sel == SEL_CTRL) ctrl_en_q <= pwdata_i[31];
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    assign flag_we[b] = wr && sel == SEL_FLAG && bank == BANK_W'(b);
    assign en_flat[b*DATA_W +: DATA_W] = en_q[b];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[b] <= '0;
      else if (wr && sel == SEL_EN && bank == BANK_W'(b)) en_q[b] <= pwdata_i;
    end
  end

  irq_hub_capture #(
    .NUM_BANK(NUM_BANK), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) i_capture (
    .clk_i, .rst_ni, .src_i,
    .clr_we_i(flag_we), .wdata_i(pwdata_i), .flag_o(flag)
  );

  irq_hub_map #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .SLOT_W(SLOT_W)
  ) i_map (
    .clk_i, .rst_ni,
    .we_i(wr && sel == SEL_SLOT), .widx_i(paddr_i[2 +: WIDX_W]),
    .wdata_i(pwdata_i), .ridx_i(paddr_i[2 +: WIDX_W]), .rdata_o(slot_rdata),
    .flag_i(flag), .en_i(en_flat), .pend_o(pend)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: prdata_o = {ctrl_en_q, 31'b0};
      SEL_FLAG: prdata_o = flag[bank*DATA_W +: DATA_W];
      SEL_EN:   prdata_o = en_q[bank];
      SEL_PEND: prdata_o = pend[bank*DATA_W +: DATA_W];
      SEL_SLOT: prdata_o = slot_rdata;
      default:  prdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= ctrl_en_q & (|pend);
  end
  assign irq_o = irq_q;

  p_irq_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(ctrl_en_q) && ($past(pend) != '0)));

  p_unmapped_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_NONE) |=> ($stable(en_q) && $stable(ctrl_en_q)));

  p_pend_ro_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_PEND) |=> ($stable(en_q) && $stable(ctrl_en_q)));
endmodule

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [63:0] src = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] slot_m [64];

  always #5 clk = ~clk;

  irq_hub i_irq_hub (
    .clk_i(clk), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .src_i(src), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called right after a falling edge; returns after a falling edge
  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk) penable = 1'b1;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk) penable = 1'b1;
    #1 d = prdata;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  task automatic chk_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apb_read(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] slot_word(input int w);
    return {slot_m[4*w+3], slot_m[4*w+2], slot_m[4*w+1], slot_m[4*w]};
  endfunction

  function automatic logic [63:0] exp_pend(input logic [63:0] f, input logic [63:0] e);
    logic [63:0] p;
    for (int n = 0; n < 64; n++) p[n] = f[slot_m[n][5:0]] & e[n];
    return p;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] en_v, pulse, pend_v;
    logic [31:0] d;
    logic        ctl;
    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 64; n++) slot_m[n] = 8'((n & ~3) + 3 - (n % 4));

    wait_n(3);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_o", {31'b0, irq}, 32'h0);
    chk("R3 pready", {31'b0, pready}, 32'h1);
    chk_rd("R1 ctrl", 12'h000, 32'h0);
    chk_rd("R1 en_lo", 12'h010, 32'h0);
    chk_rd("R1 en_hi", 12'h028, 32'h0);
    chk_rd("R1 flag_lo", 12'h008, 32'h0);
    chk_rd("R1 flag_hi", 12'h020, 32'h0);
    for (int w = 0; w < 16; w++)
      chk_rd("R1 slot reset", 12'(12'h040 + 4*w),
             {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)});

    // R8 control
    apb_write(12'h000, 32'hFFFF_FFFF);
    chk_rd("R8 ctrl only bit31", 12'h000, 32'h8000_0000);

    // R3 unmapped and misaligned
    apb_write(12'h00C, 32'hFFFF_FFFF);
    apb_write(12'h100, 32'hFFFF_FFFF);
    apb_write(12'h012, 32'hFFFF_FFFF);
    chk_rd("R3 unmapped 0x0C", 12'h00C, 32'h0);
    chk_rd("R3 unmapped 0x100", 12'h100, 32'h0);
    chk_rd("R3 unmapped 0x30", 12'h030, 32'h0);
    chk_rd("R3 en_lo untouched", 12'h010, 32'h0);
    chk_rd("R3 en_hi untouched", 12'h028, 32'h0);

    // R6 pending read-only
    apb_write(12'h014, 32'hFFFF_FFFF);
    chk_rd("R6 pend_lo ro", 12'h014, 32'h0);
    chk_rd("R6 en_lo after pend write", 12'h010, 32'h0);

    // R9/R4 latency: slot 3 -> source 0 after reset
    apb_write(12'h010, 32'h0000_0008);
    src[0] = 1'b1;
    wait_n(3);
    chk("R9 irq not yet (flag just set)", {31'b0, irq}, 32'h0);
    wait_n(1);
    chk("R9 irq one cycle after flag", {31'b0, irq}, 32'h1);
    chk_rd("R4 flag_lo bit0", 12'h008, 32'h1);
    chk_rd("R6 pend_lo slot3", 12'h014, 32'h8);

    // R5 clear, R9 fall timing, R4 held level
    apb_write(12'h008, 32'h0);
    chk("R9 irq holds old value", {31'b0, irq}, 32'h1);
    wait_n(1);
    chk("R9 irq falls after clear", {31'b0, irq}, 32'h0);
    wait_n(4);
    chk_rd("R4 held level no re-set", 12'h008, 32'h0);
    src[0] = 1'b0;
    wait_n(4);

    // R5 write-1 keeps, write-0 clears
    src[5] = 1'b1; src[40] = 1'b1;
    wait_n(3);
    src[5] = 1'b0; src[40] = 1'b0;
    wait_n(4);
    chk_rd("R4 flag_lo bit5", 12'h008, 32'h0000_0020);
    chk_rd("R4 flag_hi bit8", 12'h020, 32'h0000_0100);
    apb_write(12'h008, 32'hFFFF_FFFF);
    chk_rd("R5 write 1 keeps", 12'h008, 32'h0000_0020);
    apb_write(12'h020, 32'h0);
    chk_rd("R5 write 0 clears hi", 12'h020, 32'h0);
    chk_rd("R5 lo untouched by hi clear", 12'h008, 32'h0000_0020);

    // R5 set wins over simultaneous clear
    src[7] = 1'b1;
    @(negedge clk);
    apb_write(12'h008, 32'h0);
    chk_rd("R5 hw set wins", 12'h008, 32'h0000_0080);
    src[7] = 1'b0;
    wait_n(4);
    apb_write(12'h008, 32'h0);

    // R7 slot rewrite, upper bits stored but ignored
    apb_write(12'h044, 32'h1122_33FF);
    slot_m[4] = 8'hFF; slot_m[5] = 8'h33; slot_m[6] = 8'h22; slot_m[7] = 8'h11;
    chk_rd("R7 slot readback", 12'h044, 32'h1122_33FF);
    apb_write(12'h010, 32'h0000_0010);
    src[63] = 1'b1;
    wait_n(3);
    src[63] = 1'b0;
    wait_n(4);
    chk_rd("R7 slot4 -> source 63", 12'h014, 32'h0000_0010);
    chk_rd("R2 flag_hi bit31", 12'h020, 32'h8000_0000);
    chk("R9 irq with remapped slot", {31'b0, irq}, 32'h1);

    // R9 global enable
    apb_write(12'h000, 32'h0);
    wait_n(1);
    chk("R9 irq gated off", {31'b0, irq}, 32'h0);
    apb_write(12'h000, 32'h8000_0000);
    wait_n(1);
    chk("R9 irq gated on", {31'b0, irq}, 32'h1);

    // random mix: R2 R4 R6 R7 R9
    for (int it = 0; it < 24; it++) begin
      apb_write(12'h008, 32'h0);
      apb_write(12'h020, 32'h0);
      en_v = {$urandom, $urandom};
      apb_write(12'h010, en_v[31:0]);
      apb_write(12'h028, en_v[63:32]);
      for (int k = 0; k < 2; k++) begin
        int w = int'($urandom_range(15, 0));
        d = $urandom;
        apb_write(12'(12'h040 + 4*w), d);
        for (int b = 0; b < 4; b++) slot_m[4*w+b] = d[8*b +: 8];
        chk_rd("R7 random slot readback", 12'(12'h040 + 4*w), slot_word(w));
      end
      ctl = 1'($urandom);
      apb_write(12'h000, {ctl, 31'b0});
      pulse = {$urandom, $urandom};
      src = pulse;
      wait_n(3);
      src = '0;
      wait_n(4);
      pend_v = exp_pend(pulse, en_v);
      chk_rd("R4 random flag_lo", 12'h008, pulse[31:0]);
      chk_rd("R4 random flag_hi", 12'h020, pulse[63:32]);
      chk_rd("R6 random pend_lo", 12'h014, pend_v[31:0]);
      chk_rd("R6 random pend_hi", 12'h02C, pend_v[63:32]);
      chk("R9 random irq", {31'b0, irq}, {31'b0, ctl & (|pend_v)});
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule